// File: doc/BRIEF.md
# Oversampled Serial Receiver with Address-Mark Wakeup

This block receives asynchronous serial characters on a single line and hands them to a host through a small register-style interface. The line is sampled on a 16x oversampling clock enable. Each bit is decided by a majority vote over three samples taken around mid-bit. A frame holds 8 bits, or 9 when the nine-bit mode input is high, and its last data bit acts as an address marker. Every accepted character lands in one holding register and raises a receive-full flag. Overrun, noise and framing errors are reported on separate flag outputs.

The host works the block with three strobes: a status read, a data read and a wakeup request. A status read arms the flags that are set at that moment. A following data read clears exactly those armed flags.

On a multidrop line, a receiver that finds a message is not addressed to it asserts the wakeup request. While wakeup is pending, every non-address character is dropped silently. The next character whose marker bit is 1 releases the receiver at that bit's mid-bit vote, before the stop bit. That address character is then received and flagged in the normal way.

Top module: `rxw_receiver`

## Requirements
- R1: A frame is a low start bit, then data bits least significant first, then a stop bit. There are 8 data bits when `nine_bit`=0 and 9 when `nine_bit`=1. The bits land in `rx_data` from bit 0 upward, unused upper bits read 0, and `rx_full` is raised.
- R2: Each bit is sampled on oversample ticks 7, 8 and 9 after its start, and the majority of the three samples sets its value. A one-tick disturbance outside those ticks changes neither the data nor any flag.
- R3: If the start bit votes high at mid-bit, the receiver returns to idle and no flag or data changes.
- R4: If the three samples of any bit disagree, including the start and stop bits, `err_noise` is raised in the same cycle as `rx_full`. A single disagreeing sample does not change the bit value.
- R5: A stop bit that votes low raises `err_frame` in the same cycle as `rx_full`, and the data is still loaded.
- R6: A frame that completes while `rx_full` is set raises `err_overrun`. The frame is discarded, `rx_data` keeps the held value, and `err_frame` is not raised even if its stop bit was low.
- R7: While `err_frame` is set, completed frames are discarded with no change to data or flags.
- R8: A `rd_data` pulse clears exactly the flags that were set at the most recent `rd_status` pulse. A `rd_data` pulse with no earlier status read clears nothing, and a flag raised after the status read survives the data read.
- R9: A `set_wake` pulse raises `wake_on`. While `wake_on` is set, frames whose marker bit (the last data bit: bit 7 when `nine_bit`=0, bit 8 when `nine_bit`=1) is 0 change no flag and no data.
- R10: A frame whose marker bit is 1 clears `wake_on` at that bit's mid-bit vote, before the stop bit. That frame is then loaded and flagged normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick | input | 1 | Oversampling enable, 16 per bit time |
| rxd | input | 1 | Serial line, idle high |
| nine_bit | input | 1 | 1 selects 9-bit frames, 0 selects 8-bit frames |
| set_wake | input | 1 | Host pulse that raises the wakeup state |
| rd_status | input | 1 | Host status read strobe |
| rd_data | input | 1 | Host data read strobe |
| rx_data | output | 9 | Holding register |
| rx_full | output | 1 | Receive-full flag |
| err_overrun | output | 1 | Overrun flag |
| err_noise | output | 1 | Noise flag |
| err_frame | output | 1 | Framing flag |
| wake_on | output | 1 | Wakeup pending |

## Verification
The bench builds the block with its defaults: 16 ticks per bit, mid-bit tick 8 and a 9-bit holding register, with `os_tick` held high. With one tick per clock, a one-cycle glitch can be placed on exactly one vote sample, or just outside the sample window. That makes the majority and noise behaviour checkable cycle by cycle. The 9-bit width lets one run cover both frame lengths and both marker positions. Random frames with random length, stop level and glitches are drained after each frame. Directed sequences cover overrun, framing blocking, lone data reads and the wakeup release.

// File: rtl/rxw_pkg.sv
package rxw_pkg;
    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_DATA  = 2'd2,
        RX_STOP  = 2'd3
    } rx_state_e;

    // flag index positions inside the arm vector
    localparam int F_FULL = 3;
    localparam int F_OVR  = 2;
    localparam int F_NSE  = 1;
    localparam int F_FRM  = 0;
endpackage

// File: rtl/rxw_sync.sv
module rxw_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_in,
    output logic rx_s,
    output logic fall
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sy_t;

    sy_t sy_d, sy_q;

    always_comb begin
        sy_d       = sy_q;
        sy_d.chain = {sy_q.chain[STAGES-2:0], rx_in};
        sy_d.prev  = sy_q.chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sy_q <= '1;
        else        sy_q <= sy_d;
    end

    assign rx_s = sy_q.chain[STAGES-1];
    assign fall = sy_q.prev & ~sy_q.chain[STAGES-1];
endmodule

// File: rtl/rxw_framer.sv
module rxw_framer
    import rxw_pkg::*;
#(
    parameter int OSR = 16,
    parameter int MID = 8,
    parameter int DW  = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          rx,
    input  logic          fall,
    input  logic          nine_bit,
    output logic          done,
    output logic [DW-1:0] frame_data,
    output logic          frame_noisy,
    output logic          frame_bad,
    output logic          msb_pulse,
    output logic          msb_val
);
    localparam int CW = $clog2(OSR);
    localparam int BW = $clog2(DW + 1);
    localparam logic [CW-1:0] S0   = CW'(MID - 1);
    localparam logic [CW-1:0] S1   = CW'(MID);
    localparam logic [CW-1:0] S2   = CW'(MID + 1);
    localparam logic [CW-1:0] LAST = CW'(OSR - 1);

    typedef struct packed {
        rx_state_e     st;
        logic [CW-1:0] cnt;
        logic [1:0]    smp;
        logic [DW-1:0] sh;
        logic [BW-1:0] idx;
        logic          noisy;
        logic          done;
        logic          bad;
        logic          mp;
        logic          mv;
    } fr_t;

    fr_t fr_d, fr_q;
    logic vote, disagree, vote_now;
    logic [BW-1:0] last_idx;

    assign last_idx = nine_bit ? BW'(DW - 1) : BW'(DW - 2);
    assign vote     = (fr_q.smp[0] & fr_q.smp[1]) | (fr_q.smp[0] & rx) | (fr_q.smp[1] & rx);
    assign disagree = !((fr_q.smp[0] == fr_q.smp[1]) && (fr_q.smp[1] == rx));
    assign vote_now = tick && (fr_q.cnt == S2);

    always_comb begin
        fr_d      = fr_q;
        fr_d.done = 1'b0;
        fr_d.mp   = 1'b0;
        if (fr_q.st == RX_IDLE) begin
            if (fall && tick) begin
                fr_d.st    = RX_START;
                fr_d.cnt   = '0;
                fr_d.idx   = '0;
                fr_d.sh    = '0;
                fr_d.noisy = 1'b0;
            end
        end else if (tick) begin
            fr_d.cnt = (fr_q.cnt == LAST) ? '0 : fr_q.cnt + 1'b1;
            if (fr_q.cnt == S0) fr_d.smp[0] = rx;
            if (fr_q.cnt == S1) fr_d.smp[1] = rx;
            if (fr_q.cnt == S2) begin
                case (fr_q.st)
                    RX_START: begin
                        if (vote) fr_d.st = RX_IDLE;
                        else begin
                            fr_d.noisy = disagree;
                            fr_d.st    = RX_DATA;
                        end
                    end
                    RX_DATA: begin
                        fr_d.noisy        = fr_q.noisy | disagree;
                        fr_d.sh[fr_q.idx] = vote;
                        if (fr_q.idx == last_idx) begin
                            fr_d.mp = 1'b1;
                            fr_d.mv = vote;
                            fr_d.st = RX_STOP;
                        end else begin
                            fr_d.idx = fr_q.idx + 1'b1;
                        end
                    end
                    default: begin
                        fr_d.noisy = fr_q.noisy | disagree;
                        fr_d.bad   = ~vote;
                        fr_d.done  = 1'b1;
                        fr_d.st    = RX_IDLE;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fr_q     <= '0;
            fr_q.st  <= RX_IDLE;
            fr_q.smp <= 2'b11;
        end else begin
            fr_q <= fr_d;
        end
    end

    assign done        = fr_q.done;
    assign frame_data  = fr_q.sh;
    assign frame_noisy = fr_q.noisy;
    assign frame_bad   = fr_q.bad;
    assign msb_pulse   = fr_q.mp;
    assign msb_val     = fr_q.mv;

    AST_FALSE_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (fr_q.st == RX_START && vote_now && vote) |=> (fr_q.st == RX_IDLE && !fr_q.done)); // R3
    AST_DONE_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fr_q.done) |-> $past(fr_q.st) == RX_STOP); // R1
endmodule

// File: rtl/rxw_flags.sv
module rxw_flags
    import rxw_pkg::*;
#(
    parameter int DW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          done,
    input  logic [DW-1:0] frame_data,
    input  logic          frame_noisy,
    input  logic          frame_bad,
    input  logic          msb_pulse,
    input  logic          msb_val,
    input  logic          set_wake,
    input  logic          rd_status,
    input  logic          rd_data,
    output logic [DW-1:0] rx_data,
    output logic          rx_full,
    output logic          err_overrun,
    output logic          err_noise,
    output logic          err_frame,
    output logic          wake_on
);
    typedef struct packed {
        logic [DW-1:0] data;
        logic          full;
        logic          ovr;
        logic          nse;
        logic          frm;
        logic [3:0]    arm;
        logic          wake;
    } fl_t;

    fl_t fl_d, fl_q;

    always_comb begin
        fl_d = fl_q;
        if (rd_data) begin
            if (fl_q.arm[F_FULL]) fl_d.full = 1'b0;
            if (fl_q.arm[F_OVR])  fl_d.ovr  = 1'b0;
            if (fl_q.arm[F_NSE])  fl_d.nse  = 1'b0;
            if (fl_q.arm[F_FRM])  fl_d.frm  = 1'b0;
            fl_d.arm = '0;
        end
        if (rd_status) fl_d.arm = {fl_q.full, fl_q.ovr, fl_q.nse, fl_q.frm};
        if (set_wake) fl_d.wake = 1'b1;
        if (msb_pulse && msb_val && fl_q.wake) fl_d.wake = 1'b0;
        if (done && !fl_q.wake && !fl_q.frm) begin
            if (fl_d.full) begin
                fl_d.ovr = 1'b1;
            end else begin
                fl_d.data = frame_data;
                fl_d.full = 1'b1;
                fl_d.frm  = frame_bad;
                fl_d.nse  = frame_noisy;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fl_q <= '0;
        else        fl_q <= fl_d;
    end

    assign rx_data     = fl_q.data;
    assign rx_full     = fl_q.full;
    assign err_overrun = fl_q.ovr;
    assign err_noise   = fl_q.nse;
    assign err_frame   = fl_q.frm;
    assign wake_on     = fl_q.wake;

    AST_OVR_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fl_q.ovr) |-> $stable(fl_q.data)); // R6
    AST_OVR_HIDES_FRM: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fl_q.ovr) |-> !$rose(fl_q.frm)); // R6
    AST_FRM_WITH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fl_q.frm) |-> $rose(fl_q.full)); // R5
    AST_NSE_WITH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fl_q.nse) |-> $rose(fl_q.full)); // R4
    AST_FRM_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        fl_q.frm |=> $stable(fl_q.data)); // R7
    AST_WAKE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        fl_q.wake |=> !$rose(fl_q.full)); // R9
    AST_LONE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data && !rd_status && fl_q.arm == 4'b0 && !done)
            |=> $stable({fl_q.full, fl_q.ovr, fl_q.nse, fl_q.frm})); // R8
endmodule

// File: rtl/rxw_receiver.sv
module rxw_receiver #(
    parameter int OSR = 16,
    parameter int MID = 8,
    parameter int DW  = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          os_tick,
    input  logic          rxd,
    input  logic          nine_bit,
    input  logic          set_wake,
    input  logic          rd_status,
    input  logic          rd_data,
    output logic [DW-1:0] rx_data,
    output logic          rx_full,
    output logic          err_overrun,
    output logic          err_noise,
    output logic          err_frame,
    output logic          wake_on
);
    logic          rx_s, fall;
    logic          done, fnoisy, fbad, mpulse, mval;
    logic [DW-1:0] fdata;

    rxw_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .rx_in(rxd), .rx_s(rx_s), .fall(fall)
    );

    rxw_framer #(.OSR(OSR), .MID(MID), .DW(DW)) u_framer (
        .clk(clk), .rst_n(rst_n), .tick(os_tick), .rx(rx_s), .fall(fall),
        .nine_bit(nine_bit), .done(done), .frame_data(fdata),
        .frame_noisy(fnoisy), .frame_bad(fbad),
        .msb_pulse(mpulse), .msb_val(mval)
    );

    rxw_flags #(.DW(DW)) u_flags (
        .clk(clk), .rst_n(rst_n), .done(done), .frame_data(fdata),
        .frame_noisy(fnoisy), .frame_bad(fbad), .msb_pulse(mpulse),
        .msb_val(mval), .set_wake(set_wake), .rd_status(rd_status),
        .rd_data(rd_data), .rx_data(rx_data), .rx_full(rx_full),
        .err_overrun(err_overrun), .err_noise(err_noise),
        .err_frame(err_frame), .wake_on(wake_on)
    );
endmodule

// File: tb/rxw_receiver_test.sv
module rxw_receiver_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic os_tick = 1'b1;
    logic rxd = 1'b1;
    logic nine_bit = 1'b0;
    logic set_wake = 1'b0;
    logic rd_status = 1'b0;
    logic rd_data = 1'b0;
    logic [8:0] rx_data;
    logic rx_full, err_overrun, err_noise, err_frame, wake_on;

    int n_chk = 0;
    int n_bad = 0;
    logic wake_at_stop;
    bit finished = 0;

    always #5 clk = ~clk;

    rxw_receiver uut (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd(rxd),
        .nine_bit(nine_bit), .set_wake(set_wake), .rd_status(rd_status),
        .rd_data(rd_data), .rx_data(rx_data), .rx_full(rx_full),
        .err_overrun(err_overrun), .err_noise(err_noise),
        .err_frame(err_frame), .wake_on(wake_on)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [8:0] exp_data(input logic [8:0] v, input logic m);
        return m ? v : {1'b0, v[7:0]};
    endfunction

    // gb: bit index to disturb (0 = start, nb+1 = stop), gc: cycle within bit
    task automatic send(input logic [8:0] v, input logic m, input logic stop_ok,
                        input int gb, input int gc);
        int nb;
        nb = m ? 9 : 8;
        nine_bit = m;
        for (int b = 0; b < nb + 2; b++) begin
            logic lvl;
            lvl = (b == 0) ? 1'b0 : (b == nb + 1) ? stop_ok : v[b-1];
            for (int c = 0; c < 16; c++) begin
                @(negedge clk);
                rxd = (b == gb && c == gc) ? ~lvl : lvl;
                if (b == nb + 1 && c == 4) wake_at_stop = wake_on;
            end
        end
        @(negedge clk);
        rxd = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic pulse_status();
        @(negedge clk); rd_status = 1'b1;
        @(negedge clk); rd_status = 1'b0;
    endtask

    task automatic pulse_data();
        @(negedge clk); rd_data = 1'b1;
        @(negedge clk); rd_data = 1'b0;
    endtask

    task automatic drain();
        pulse_status();
        pulse_data();
        @(negedge clk);
    endtask

    task automatic chk_flags(input string tag, input logic f, input logic o,
                             input logic nz, input logic fe);
        chk({tag, " full"}, rx_full, f);
        chk({tag, " ovr"}, err_overrun, o);
        chk({tag, " noise"}, err_noise, nz);
        chk({tag, " frame"}, err_frame, fe);
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [8:0] a, b2;
        void'($urandom(32'd77));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // reset state
        chk_flags("R1 reset", 0, 0, 0, 0);
        chk("R9 reset wake", wake_on, 0);
        chk("R1 reset data", rx_data, 0);

        // R3 false start: short low pulse
        @(negedge clk); rxd = 1'b0;
        repeat (5) @(negedge clk); rxd = 1'b1;
        repeat (40) @(negedge clk);
        chk_flags("R3 false start", 0, 0, 0, 0);

        // R1 basic 8-bit and 9-bit frames
        send(9'h1A5, 1'b0, 1'b1, -1, 0);
        chk("R1 data 8bit", rx_data, 9'h0A5);
        chk_flags("R1 8bit", 1, 0, 0, 0);
        drain();
        chk_flags("R8 cleared", 0, 0, 0, 0);
        send(9'h15A, 1'b1, 1'b1, -1, 0);
        chk("R1 data 9bit", rx_data, 9'h15A);
        drain();

        // R2 glitch outside sample window: no effect
        send(9'h033, 1'b0, 1'b1, 3, 3);
        chk("R2 outside window data", rx_data, 9'h033);
        chk_flags("R2 outside window", 1, 0, 0, 0);
        drain();

        // R4 single-sample glitch on start bit
        send(9'h0C3, 1'b0, 1'b1, 0, 8);
        chk("R4 start glitch data", rx_data, 9'h0C3);
        chk_flags("R4 start glitch", 1, 0, 1, 0);
        drain();

        // R5 framing error still loads data
        send(9'h071, 1'b0, 1'b0, -1, 0);
        chk("R5 data", rx_data, 9'h071);
        chk_flags("R5 framing", 1, 0, 0, 1);

        // R7 blocked while framing flag set
        send(9'h0EE, 1'b0, 1'b1, -1, 0);
        chk("R7 data kept", rx_data, 9'h071);
        chk_flags("R7 blocked", 1, 0, 0, 1);
        drain();
        chk_flags("R8 clear after framing", 0, 0, 0, 0);

        // R6 overrun: second frame with bad stop, first still held
        send(9'h011, 1'b0, 1'b1, -1, 0);
        send(9'h022, 1'b0, 1'b0, -1, 0);
        chk("R6 data kept", rx_data, 9'h011);
        chk_flags("R6 overrun", 1, 1, 0, 0);
        drain();
        chk_flags("R6 cleared", 0, 0, 0, 0);

        // R8 lone data read clears nothing; flag set after status read survives
        send(9'h044, 1'b0, 1'b1, -1, 0);
        pulse_data();
        chk_flags("R8 lone read", 1, 0, 0, 0);
        drain();
        pulse_status();
        send(9'h055, 1'b0, 1'b1, -1, 0);
        pulse_data();
        chk_flags("R8 late flag", 1, 0, 0, 0);
        drain();
        chk_flags("R8 final clear", 0, 0, 0, 0);

        // R9 / R10 wakeup, 8-bit marker at bit 7
        @(negedge clk); set_wake = 1'b1;
        @(negedge clk); set_wake = 1'b0;
        chk("R9 wake set", wake_on, 1);
        send(9'h07F, 1'b0, 1'b0, 2, 8);
        chk_flags("R9 quiet", 0, 0, 0, 0);
        chk("R9 wake held", wake_on, 1);
        chk("R9 data untouched", rx_data, 9'h055);
        send(9'h0A3, 1'b0, 1'b1, -1, 0);
        chk("R10 wake cleared before stop", wake_at_stop, 0);
        chk("R10 data", rx_data, 9'h0A3);
        chk_flags("R10 flags", 1, 0, 0, 0);
        drain();

        // R9 / R10 with 9-bit frames, marker at bit 8
        @(negedge clk); set_wake = 1'b1;
        @(negedge clk); set_wake = 1'b0;
        send(9'h0FF, 1'b1, 1'b1, -1, 0);
        chk_flags("R9 quiet 9bit", 0, 0, 0, 0);
        send(9'h101, 1'b1, 1'b1, -1, 0);
        chk("R10 wake 9bit", wake_at_stop, 0);
        chk("R10 data 9bit", rx_data, 9'h101);
        drain();

        // random frames, drained after each
        for (int i = 0; i < 40; i++) begin
            logic m, sok, nz;
            int nb, gb;
            a   = 9'($urandom);
            m   = 1'($urandom);
            sok = ($urandom % 4) != 0;
            nz  = ($urandom % 4) == 0;
            nb  = m ? 9 : 8;
            gb  = nz ? int'($urandom % (nb + 2)) : -1;
            send(a, m, sok, gb, 8);
            b2 = exp_data(a, m);
            chk("R1 rand data", rx_data, b2);
            chk_flags("R4 R5 rand", 1, 0, nz, ~sok);
            drain();
            chk_flags("R8 rand clear", 0, 0, 0, 0);
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule